// File: doc/BRIEF.md
# Power-On Self-Test Sequencer

This block runs a built-in self-test over a processor's small on-chip storage arrays. It starts either when the chip leaves reset with the run strap high, or when a test-port command asks for a run. It then walks a fixed three-phase schedule. In the first phase, four RAM arrays get a March C test in lockstep while a signature engine compacts the microcode ROM. The second phase applies March C to the two translation-tag arrays. The third phase compacts the decode PLA. Every detected fault sets one bit of a 9-bit failure vector, and a vector of all zeros means pass.

A run started from reset copies the vector, zero-extended, into a 32-bit result word and then raises the start-up signal, whether the test passed or failed. A run started from the test port leaves the result word alone and parks the vector in a shift register, which the test port reads out serially. A second strap, sampled in the same way, puts the chip into a float mode instead. In float mode the pad enable is dropped, no test runs, and only a new reset leaves the mode. The arrays themselves and the test-port state machine are outside the block. The block only drives generic address, data and write-enable lines and reads back the data.

Top module: `selftest_sequencer`

## Requirements
- R1: When `strapInit` is high in the last reset cycle, a self-test runs after reset. With fault-free arrays, `resultWord` is 0 when `startupGo` rises. During reset `startupGo`, `testBusy` and `resultWord` are 0 and `padOe` is 1.
- R2: When `strapInit` and `strapFlush` are both low in the last reset cycle, `startupGo` rises on the first clock edge after reset. No array write occurs and `testBusy` stays low.
- R3: When `strapFlush` is high in the last reset cycle, the block enters float mode, and this takes precedence over `strapInit`. In float mode `padOe` is 0, `resultWord`, `startupGo`, `testBusy` and `tdo` are held at 0, and `runSelfTest` is ignored. Only a new reset leaves float mode.
- R4: Phase order is fixed. Phase 1 runs March C on array indices 0 to 3 together with the ROM signature. Phase 2 runs March C on indices 4 and 5, and starts only after every phase-1 write. Phase 3 runs the PLA signature.
- R5: March C issues these elements in order: ascending w0; ascending r0,w1; ascending r1,w0; descending r0,w1; descending r1,w0; ascending r0. That is 5 writes per address per array, and any read mismatch, including stuck-at-0 and stuck-at-1 bits, marks the array.
- R6: Array index k on the memory ports maps to failure-vector bit 0, 1, 2, 7, 5, 6 for k = 0 to 5. The arrays are, in index order: data-cache physical tags, instruction-cache physical tags, data-cache data, instruction-cache data, data-cache linear tags and instruction-cache linear tags.
- R7: Each signature starts at 0xFFFF and takes one 16-bit word per address from 0 upward. The update is next = ((s<<1) ^ (s[15] ? 0x1021 : 0)) ^ word. A final value that differs from `ROM_SIG` sets bit 3, and one that differs from `PLA_SIG` sets bit 4.
- R8: A reset-started run writes the vector to `resultWord[8:0]` with bits 31:9 zero. It raises `startupGo` even when bits are set, and `startupGo` then stays high until reset.
- R9: A `runSelfTest` pulse while idle after start-up runs the same phases. It leaves `resultWord` unchanged and loads the vector into the shift register when `testBusy` falls. `tdo` shows bit 0 first, each `shiftEn` cycle moves the next bit out, and zeros fill in behind.
- R10: A `tapRst` or `tapInstrUpdate` cycle clears the shift register, so `tdo` reads 0 for all 9 positions.
- R11: A `runSelfTest` pulse while `testBusy` is high has no effect on the running test.
- R12: Bit 8 of the vector, the datapath bit, is always 0, even when all array, ROM and PLA tests fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; straps are sampled while it is high |
| strapInit | input | 1 | Run-self-test strap |
| strapFlush | input | 1 | Float-mode strap |
| runSelfTest | input | 1 | Test-port run command pulse |
| tapRst | input | 1 | Test-port reset, clears the shift register |
| tapInstrUpdate | input | 1 | Test-port instruction change, clears the shift register |
| shiftEn | input | 1 | Shift the result register by one bit |
| memRdData | input | 6*MEM_WIDTH | Read data of the six RAM arrays, index k at bits k*MEM_WIDTH upward |
| romRdData | input | 16 | ROM word at `romAddr` |
| plaRdData | input | 16 | PLA word at `plaAddr` |
| memAddr | output | clog2(MEM_DEPTH) | Shared RAM address |
| memWrData | output | MEM_WIDTH | Shared RAM write data |
| memWe | output | 6 | Per-array write enable |
| romAddr | output | clog2(ROM_DEPTH) | ROM address |
| plaAddr | output | clog2(PLA_DEPTH) | PLA address |
| resultWord | output | 32 | Result register |
| startupGo | output | 1 | Normal start-up may proceed |
| testBusy | output | 1 | A self-test run is in progress |
| tdo | output | 1 | Serial result bit |
| padOe | output | 1 | Pad output enable, low in float mode |

## Verification
The assertions assume that the arrays return read data in the same cycle as the address, and that the straps are steady over the last reset cycle. The bench array models read combinationally and apply stuck-bit masks. The bench changes the straps only at negative clock edges, while reset is held. The assertions also assume that the test-port clear inputs and `shiftEn` are never used in the same cycle. The bench keeps each of these to single-cycle pulses, issued one at a time.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
  localparam int VEC_W   = 9;
  localparam int NUM_MEM = 6;

  typedef enum logic [2:0] {
    S_BOOT, S_IDLE, S_PH1, S_PH2, S_PH3, S_FIN, S_FLOAT
  } ctrlState_t;

  typedef struct packed {
    logic               marchStart;
    logic [NUM_MEM-1:0] marchMask;
    logic               sigStart;
    logic               sigSelPla;
    logic               clearVec;
    logic               loadResult;
    logic               loadShift;
  } dpStrobe_t;

  function automatic logic [15:0] lfsrStep(input logic [15:0] cur, input logic [15:0] word);
    lfsrStep = {cur[14:0], 1'b0} ^ (cur[15] ? 16'h1021 : 16'h0000) ^ word;
  endfunction
endpackage

// File: rtl/st_march.sv
module st_march #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int NMEM  = 6,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [NMEM-1:0]         mask,
  input  logic [NMEM*WIDTH-1:0]   rdData,
  output logic [AW-1:0]           memAddr,
  output logic [WIDTH-1:0]        memWrData,
  output logic [NMEM-1:0]         memWe,
  output logic [NMEM-1:0]         failSet,
  output logic                    done
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic            running, opSel;
  logic [2:0]      elem;
  logic [AW-1:0]   addr;
  logic [NMEM-1:0] maskQ;

  logic isRead, readVal, writeVal, singleOp, lastOp, desc, atEnd;
  logic [WIDTH-1:0] expWord;

  always_comb begin
    singleOp = (elem == 3'd0) || (elem == 3'd5);
    isRead   = (elem != 3'd0) && !opSel;
    readVal  = (elem == 3'd2) || (elem == 3'd4);
    writeVal = (elem == 3'd1) || (elem == 3'd3);
    lastOp   = singleOp || opSel;
    desc     = (elem == 3'd3) || (elem == 3'd4);
    atEnd    = desc ? (addr == '0) : (addr == LAST);
    expWord  = {WIDTH{readVal}};
    memAddr   = addr;
    memWrData = {WIDTH{writeVal}};
    memWe     = (running && !isRead) ? maskQ : '0;
    done      = running && lastOp && atEnd && (elem == 3'd5);
    for (int k = 0; k < NMEM; k++)
      failSet[k] = running && isRead && maskQ[k] && (rdData[k*WIDTH +: WIDTH] != expWord);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0; opSel <= 1'b0; elem <= '0; addr <= '0; maskQ <= '0;
    end else if (start) begin
      running <= 1'b1; opSel <= 1'b0; elem <= '0; addr <= '0; maskQ <= mask;
    end else if (running) begin
      if (!lastOp) begin
        opSel <= 1'b1;
      end else begin
        opSel <= 1'b0;
        if (!atEnd)                 addr <= desc ? addr - 1'b1 : addr + 1'b1;
        else if (elem == 3'd5)      running <= 1'b0;
        else begin
          elem <= elem + 3'd1;
          addr <= ((elem == 3'd2) || (elem == 3'd3)) ? LAST : '0;
        end
      end
    end
  end

  // R5: a run opens with a zero write to every selected array
  assert_first_write_zero_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> (memWe == maskQ) && (memWrData == '0));
endmodule

// File: rtl/st_sig.sv
module st_sig import selftest_pkg::*; #(
  parameter int ROM_DEPTH = 32,
  parameter int PLA_DEPTH = 24,
  parameter logic [15:0] ROM_SIG = 16'h0000,
  parameter logic [15:0] PLA_SIG = 16'h0000,
  localparam int RAW = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1,
  localparam int PAW = (PLA_DEPTH > 1) ? $clog2(PLA_DEPTH) : 1,
  localparam int CW  = (RAW > PAW) ? RAW : PAW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           selPla,
  input  logic [15:0]    romData,
  input  logic [15:0]    plaData,
  output logic [RAW-1:0] romAddr,
  output logic [PAW-1:0] plaAddr,
  output logic           done,
  output logic           failRom,
  output logic           failPla
);
  logic          running, selQ, lastWord;
  logic [CW-1:0] cnt;
  logic [15:0]   lfsr, nextLfsr;

  always_comb begin
    nextLfsr = lfsrStep(lfsr, selQ ? plaData : romData);
    lastWord = (cnt == (selQ ? CW'(PLA_DEPTH - 1) : CW'(ROM_DEPTH - 1)));
    romAddr  = cnt[RAW-1:0];
    plaAddr  = cnt[PAW-1:0];
    done     = running && lastWord;
    failRom  = done && !selQ && (nextLfsr != ROM_SIG);
    failPla  = done &&  selQ && (nextLfsr != PLA_SIG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0; selQ <= 1'b0; cnt <= '0; lfsr <= 16'hFFFF;
    end else if (start) begin
      running <= 1'b1; selQ <= selPla; cnt <= '0; lfsr <= 16'hFFFF;
    end else if (running) begin
      lfsr <= nextLfsr;
      if (lastWord) running <= 1'b0;
      else          cnt <= cnt + 1'b1;
    end
  end

  // R7: completion is a single-cycle event
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);
endmodule

// File: rtl/st_datapath.sv
module st_datapath import selftest_pkg::*; #(
  parameter int MEM_WIDTH = 8,
  parameter int MEM_DEPTH = 16,
  parameter int ROM_DEPTH = 32,
  parameter int PLA_DEPTH = 24,
  parameter logic [15:0] ROM_SIG = 16'h0000,
  parameter logic [15:0] PLA_SIG = 16'h0000,
  localparam int MAW = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1,
  localparam int RAW = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1,
  localparam int PAW = (PLA_DEPTH > 1) ? $clog2(PLA_DEPTH) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  dpStrobe_t                      strobe,
  input  logic                           tapRst,
  input  logic                           tapInstrUpdate,
  input  logic                           shiftEn,
  input  logic [NUM_MEM*MEM_WIDTH-1:0]   memRdData,
  input  logic [15:0]                    romRdData,
  input  logic [15:0]                    plaRdData,
  output logic [MAW-1:0]                 memAddr,
  output logic [MEM_WIDTH-1:0]           memWrData,
  output logic [NUM_MEM-1:0]             memWe,
  output logic [RAW-1:0]                 romAddr,
  output logic [PAW-1:0]                 plaAddr,
  output logic                           marchDone,
  output logic                           sigDone,
  output logic [31:0]                    resultWord,
  output logic                           tdoBit
);
  logic [NUM_MEM-1:0] mFail;
  logic               sFailRom, sFailPla;
  logic [VEC_W-1:0]   failVec, vecSet, shiftReg;

  st_march #(.WIDTH(MEM_WIDTH), .DEPTH(MEM_DEPTH), .NMEM(NUM_MEM)) uMarch (
    .clk(clk), .rst(rst), .start(strobe.marchStart), .mask(strobe.marchMask),
    .rdData(memRdData), .memAddr(memAddr), .memWrData(memWrData), .memWe(memWe),
    .failSet(mFail), .done(marchDone));

  st_sig #(.ROM_DEPTH(ROM_DEPTH), .PLA_DEPTH(PLA_DEPTH), .ROM_SIG(ROM_SIG), .PLA_SIG(PLA_SIG)) uSig (
    .clk(clk), .rst(rst), .start(strobe.sigStart), .selPla(strobe.sigSelPla),
    .romData(romRdData), .plaData(plaRdData), .romAddr(romAddr), .plaAddr(plaAddr),
    .done(sigDone), .failRom(sFailRom), .failPla(sFailPla));

  // Bit positions are decoded outside the block, so the mapping is fixed.
  always_comb begin
    vecSet    = '0;
    vecSet[0] = mFail[0];
    vecSet[1] = mFail[1];
    vecSet[2] = mFail[2];
    vecSet[3] = sFailRom;
    vecSet[4] = sFailPla;
    vecSet[5] = mFail[4];
    vecSet[6] = mFail[5];
    vecSet[7] = mFail[3];
    tdoBit    = shiftReg[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      failVec <= '0; resultWord <= '0; shiftReg <= '0;
    end else begin
      if (strobe.clearVec) failVec <= '0;
      else                 failVec <= failVec | vecSet;
      if (strobe.loadResult) resultWord <= {{(32-VEC_W){1'b0}}, failVec};
      if (tapRst || tapInstrUpdate) shiftReg <= '0;
      else if (strobe.loadShift)    shiftReg <= failVec;
      else if (shiftEn)             shiftReg <= {1'b0, shiftReg[VEC_W-1:1]};
    end
  end

  // R8: only a reset-started completion touches the result word
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadResult |=> $stable(resultWord));
  // R5: failure bits are sticky within a run
  assert_vec_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !strobe.clearVec |=> ((failVec & $past(failVec)) == $past(failVec)));
  // R10: a test-port clear empties the serial path
  assert_shift_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (tapRst || tapInstrUpdate) |=> (tdoBit == 1'b0));
endmodule

// File: rtl/st_ctrl.sv
module st_ctrl import selftest_pkg::*; (
  input  logic      clk,
  input  logic      rst,
  input  logic      strapInit,
  input  logic      strapFlush,
  input  logic      runSelfTest,
  input  logic      marchDone,
  input  logic      sigDone,
  output dpStrobe_t strobe,
  output logic      floatMode,
  output logic      startupGo,
  output logic      testBusy
);
  localparam logic [NUM_MEM-1:0] PH1_MASK = 6'b001111;
  localparam logic [NUM_MEM-1:0] PH2_MASK = 6'b110000;

  ctrlState_t state, nextState;
  logic initQ, flushQ, fromReset, marchFin, sigFin;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      S_BOOT: begin
        if (flushQ) nextState = S_FLOAT;
        else if (initQ) begin
          strobe.clearVec = 1'b1; strobe.marchStart = 1'b1; strobe.marchMask = PH1_MASK;
          strobe.sigStart = 1'b1; nextState = S_PH1;
        end else nextState = S_IDLE;
      end
      S_IDLE: if (runSelfTest) begin
        strobe.clearVec = 1'b1; strobe.marchStart = 1'b1; strobe.marchMask = PH1_MASK;
        strobe.sigStart = 1'b1; nextState = S_PH1;
      end
      S_PH1: if ((marchFin || marchDone) && (sigFin || sigDone)) begin
        strobe.marchStart = 1'b1; strobe.marchMask = PH2_MASK; nextState = S_PH2;
      end
      S_PH2: if (marchDone) begin
        strobe.sigStart = 1'b1; strobe.sigSelPla = 1'b1; nextState = S_PH3;
      end
      S_PH3: if (sigDone) nextState = S_FIN;
      S_FIN: begin
        if (fromReset) strobe.loadResult = 1'b1;
        else           strobe.loadShift  = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_FLOAT;
    endcase
    floatMode = (state == S_FLOAT);
    testBusy  = (state == S_PH1) || (state == S_PH2) || (state == S_PH3) || (state == S_FIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_BOOT; initQ <= strapInit; flushQ <= strapFlush;
      fromReset <= 1'b0; marchFin <= 1'b0; sigFin <= 1'b0; startupGo <= 1'b0;
    end else begin
      state    <= nextState;
      marchFin <= (state == S_PH1) && (nextState == S_PH1) && (marchFin || marchDone);
      sigFin   <= (state == S_PH1) && (nextState == S_PH1) && (sigFin || sigDone);
      if (state == S_BOOT) fromReset <= initQ;
      else if (state == S_IDLE && runSelfTest) fromReset <= 1'b0;
      if ((state == S_BOOT && !flushQ && !initQ) || (state == S_FIN && fromReset))
        startupGo <= 1'b1;
    end
  end

  // R8: start-up, once signalled, is held until reset
  assert_startup_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    startupGo |=> startupGo);
  // R3: float mode is left only through reset
  assert_float_latched_R3: assert property (@(posedge clk) disable iff (rst)
    floatMode |=> floatMode);
  // R4: phase 2 is entered only from phase 1
  assert_phase2_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_PH2 && $past(state) != S_PH2) |-> $past(state) == S_PH1);
  // R4: phase 3 is entered only from phase 2
  assert_phase3_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_PH3 && $past(state) != S_PH3) |-> $past(state) == S_PH2);
endmodule

// File: rtl/selftest_sequencer.sv
module selftest_sequencer import selftest_pkg::*; #(
  parameter int MEM_WIDTH = 8,
  parameter int MEM_DEPTH = 16,
  parameter int ROM_DEPTH = 32,
  parameter int PLA_DEPTH = 24,
  parameter logic [15:0] ROM_SIG = 16'h0000,
  parameter logic [15:0] PLA_SIG = 16'h0000,
  localparam int MAW = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1,
  localparam int RAW = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1,
  localparam int PAW = (PLA_DEPTH > 1) ? $clog2(PLA_DEPTH) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         strapInit,
  input  logic                         strapFlush,
  input  logic                         runSelfTest,
  input  logic                         tapRst,
  input  logic                         tapInstrUpdate,
  input  logic                         shiftEn,
  input  logic [NUM_MEM*MEM_WIDTH-1:0] memRdData,
  input  logic [15:0]                  romRdData,
  input  logic [15:0]                  plaRdData,
  output logic [MAW-1:0]               memAddr,
  output logic [MEM_WIDTH-1:0]         memWrData,
  output logic [NUM_MEM-1:0]           memWe,
  output logic [RAW-1:0]               romAddr,
  output logic [PAW-1:0]               plaAddr,
  output logic [31:0]                  resultWord,
  output logic                         startupGo,
  output logic                         testBusy,
  output logic                         tdo,
  output logic                         padOe
);
  dpStrobe_t   strobe;
  logic        marchDone, sigDone, floatMode, goInt, busyInt, tdoInt;
  logic [31:0] resultInt;

  st_ctrl uCtrl (
    .clk(clk), .rst(rst), .strapInit(strapInit), .strapFlush(strapFlush),
    .runSelfTest(runSelfTest), .marchDone(marchDone), .sigDone(sigDone),
    .strobe(strobe), .floatMode(floatMode), .startupGo(goInt), .testBusy(busyInt));

  st_datapath #(.MEM_WIDTH(MEM_WIDTH), .MEM_DEPTH(MEM_DEPTH), .ROM_DEPTH(ROM_DEPTH),
                .PLA_DEPTH(PLA_DEPTH), .ROM_SIG(ROM_SIG), .PLA_SIG(PLA_SIG)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .tapRst(tapRst), .tapInstrUpdate(tapInstrUpdate),
    .shiftEn(shiftEn), .memRdData(memRdData), .romRdData(romRdData), .plaRdData(plaRdData),
    .memAddr(memAddr), .memWrData(memWrData), .memWe(memWe), .romAddr(romAddr),
    .plaAddr(plaAddr), .marchDone(marchDone), .sigDone(sigDone),
    .resultWord(resultInt), .tdoBit(tdoInt));

  // Float mode: pad enable drops and pin-level outputs are held quiet.
  always_comb begin
    padOe      = !floatMode;
    resultWord = floatMode ? '0 : resultInt;
    startupGo  = !floatMode && goInt;
    testBusy   = !floatMode && busyInt;
    tdo        = !floatMode && tdoInt;
  end
endmodule

// File: tb/tb_selftest_sequencer.sv
module tb_selftest_sequencer;
  localparam int W = 8, D = 16, RD = 32, PD = 24;
  localparam int MAW = $clog2(D), RAW = $clog2(RD), PAW = $clog2(PD);

  function automatic logic [15:0] romWord(input int i);
    romWord = 16'(i * 499) ^ 16'hA55A;
  endfunction
  function automatic logic [15:0] plaWord(input int i);
    plaWord = 16'(i * 183 + 60);
  endfunction
  // R7 signature, computed from the requirement text
  function automatic logic [15:0] refSig(input int n, input bit pla);
    logic [15:0] s, w;
    s = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      w = pla ? plaWord(i) : romWord(i);
      s = ({s[14:0], 1'b0} ^ (s[15] ? 16'h1021 : 16'h0000)) ^ w;
    end
    refSig = s;
  endfunction
  localparam logic [15:0] ROM_SIG_E = refSig(RD, 1'b0);
  localparam logic [15:0] PLA_SIG_E = refSig(PD, 1'b1);

  logic clk = 0, rst = 1, strapInit = 0, strapFlush = 0, runSelfTest = 0;
  logic tapRst = 0, tapInstrUpdate = 0, shiftEn = 0;
  logic [6*W-1:0] memRdData;
  logic [15:0] romRdData, plaRdData, romFlip = 0, plaFlip = 0;
  logic [MAW-1:0] memAddr;
  logic [W-1:0] memWrData;
  logic [5:0] memWe;
  logic [RAW-1:0] romAddr;
  logic [PAW-1:0] plaAddr;
  logic [31:0] resultWord;
  logic startupGo, testBusy, tdo, padOe;

  always #5 clk = ~clk;

  selftest_sequencer #(.MEM_WIDTH(W), .MEM_DEPTH(D), .ROM_DEPTH(RD), .PLA_DEPTH(PD),
                       .ROM_SIG(ROM_SIG_E), .PLA_SIG(PLA_SIG_E)) dut (
    .clk(clk), .rst(rst), .strapInit(strapInit), .strapFlush(strapFlush),
    .runSelfTest(runSelfTest), .tapRst(tapRst), .tapInstrUpdate(tapInstrUpdate),
    .shiftEn(shiftEn), .memRdData(memRdData), .romRdData(romRdData), .plaRdData(plaRdData),
    .memAddr(memAddr), .memWrData(memWrData), .memWe(memWe), .romAddr(romAddr),
    .plaAddr(plaAddr), .resultWord(resultWord), .startupGo(startupGo), .testBusy(testBusy),
    .tdo(tdo), .padOe(padOe));

  // Array models with stuck-bit masks
  logic [W-1:0] mem [6][D];
  logic [W-1:0] stuck1 [6];
  logic [W-1:0] stuck0 [6];
  always_comb begin
    for (int k = 0; k < 6; k++)
      memRdData[k*W +: W] = (mem[k][memAddr] | stuck1[k]) & ~stuck0[k];
    romRdData = romWord(int'(romAddr)) ^ romFlip;
    plaRdData = plaWord(int'(plaAddr)) ^ plaFlip;
  end

  int cyc = 0, lastLowWr = 0, firstHighWr = 0;
  int wrCnt [6];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      for (int k = 0; k < 6; k++) if (memWe[k]) begin
        mem[k][memAddr] <= memWrData;
        wrCnt[k] = wrCnt[k] + 1;
      end
      if (|memWe[3:0]) lastLowWr = cyc;
      if ((|memWe[5:4]) && firstHighWr == 0) firstHighWr = cyc;
    end
  end

  int checks = 0, errors = 0;

  always @(posedge clk) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mapBit(input int k);
    case (k)
      0: mapBit = 0; 1: mapBit = 1; 2: mapBit = 2;
      3: mapBit = 7; 4: mapBit = 5; default: mapBit = 6;
    endcase
  endfunction

  task automatic clearFaults();
    for (int k = 0; k < 6; k++) begin stuck1[k] = '0; stuck0[k] = '0; end
    romFlip = 0; plaFlip = 0;
  endtask

  task automatic clearMon();
    for (int k = 0; k < 6; k++) wrCnt[k] = 0;
    lastLowWr = 0; firstHighWr = 0;
  endtask

  task automatic applyReset(input logic init, input logic flush);
    @(negedge clk);
    rst = 1; strapInit = init; strapFlush = flush;
    runSelfTest = 0; shiftEn = 0; tapRst = 0; tapInstrUpdate = 0;
    repeat (3) @(negedge clk);
    clearMon();
    rst = 0; strapInit = 0; strapFlush = 0;
  endtask

  task automatic waitStartup(input string req);
    bit seen = 0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge clk);
      seen = startupGo;
    end
    chk(req, {31'b0, seen}, 32'd1);
  endtask

  task automatic runBist();
    bit fin = 0;
    runSelfTest = 1; @(negedge clk); runSelfTest = 0;
    chk("R9 busy after command", {31'b0, testBusy}, 32'd1);
    for (int i = 0; i < 4000 && !fin; i++) begin
      @(negedge clk);
      fin = !testBusy;
    end
    chk("R9 run completes", {31'b0, fin}, 32'd1);
  endtask

  task automatic shiftOut(output logic [8:0] v, output logic extra);
    for (int i = 0; i < 9; i++) begin
      v[i] = tdo; shiftEn = 1; @(negedge clk); shiftEn = 0;
    end
    extra = tdo;
  endtask

  task automatic testResetState();
    clearFaults();
    rst = 1; strapInit = 1;
    repeat (2) @(negedge clk);
    chk("R1 reset startupGo", {31'b0, startupGo}, 0);
    chk("R1 reset testBusy", {31'b0, testBusy}, 0);
    chk("R1 reset resultWord", resultWord, 0);
    chk("R1 reset padOe", {31'b0, padOe}, 1);
  endtask

  task automatic testNoInit();
    applyReset(0, 0);
    @(negedge clk);
    chk("R2 startupGo after one edge", {31'b0, startupGo}, 1);
    repeat (20) @(negedge clk);
    chk("R2 no test busy", {31'b0, testBusy}, 0);
    chk("R2 no array writes", wrCnt[0] + wrCnt[3] + wrCnt[5], 0);
  endtask

  task automatic testPassRun();
    clearFaults();
    applyReset(1, 0);
    @(negedge clk);
    chk("R1 busy during run", {31'b0, testBusy}, 1);
    waitStartup("R1 startup after run");
    chk("R1 pass result", resultWord, 0);
    for (int k = 0; k < 6; k++) chk("R5 writes per array", wrCnt[k], 5 * D);
    chk("R4 phase 2 after phase 1", {31'b0, (firstHighWr > lastLowWr)}, 1);
  endtask

  task automatic testArrayFaults();
    for (int k = 0; k < 6; k++) begin
      clearFaults();
      if (k % 2 == 1) stuck1[k] = 8'h10; else stuck0[k] = 8'h04;
      applyReset(1, 0);
      waitStartup("R8 startup despite failure");
      chk("R6 R5 array fault bit", resultWord, 32'd1 << mapBit(k));
    end
  endtask

  task automatic testSigFaults();
    clearFaults(); romFlip = 16'h0100;
    applyReset(1, 0); waitStartup("R7 startup");
    chk("R7 ROM fault", resultWord, 32'h008);
    clearFaults(); plaFlip = 16'h0001;
    applyReset(1, 0); waitStartup("R7 startup");
    chk("R7 PLA fault", resultWord, 32'h010);
  endtask

  task automatic testAllFaults();
    clearFaults();
    for (int k = 0; k < 6; k++) stuck1[k] = 8'h80;
    romFlip = 16'h8000; plaFlip = 16'h0400;
    applyReset(1, 0); waitStartup("R12 startup");
    chk("R12 R8 all faults, bit 8 and upper zero", resultWord, 32'h0FF);
  endtask

  task automatic testRunBist();
    logic [8:0] v; logic extra;
    clearFaults();
    applyReset(1, 0); waitStartup("R9 startup");
    chk("R9 clean result before command", resultWord, 0);
    stuck1[3] = 8'h01;
    clearMon();
    runBist();
    chk("R9 result word untouched", resultWord, 0);
    chk("R9 same phases writes", wrCnt[4], 5 * D);
    shiftOut(v, extra);
    chk("R9 shifted vector", {23'b0, v}, 32'h080);
    chk("R9 zero fill", {31'b0, extra}, 0);
  endtask

  task automatic testTapClear();
    logic [8:0] v; logic extra;
    clearFaults(); stuck0[0] = 8'h02;
    runBist();
    tapRst = 1; @(negedge clk); tapRst = 0;
    shiftOut(v, extra);
    chk("R10 cleared by tapRst", {23'b0, v}, 0);
    runBist();
    tapInstrUpdate = 1; @(negedge clk); tapInstrUpdate = 0;
    shiftOut(v, extra);
    chk("R10 cleared by instruction update", {23'b0, v}, 0);
  endtask

  task automatic testBusyIgnore();
    logic [8:0] v; logic extra;
    clearFaults(); stuck1[2] = 8'h40;
    clearMon();
    runSelfTest = 1; @(negedge clk); runSelfTest = 0;
    repeat (100) @(negedge clk);
    runSelfTest = 1; @(negedge clk); runSelfTest = 0;
    repeat (2000) @(negedge clk);
    chk("R11 run idle at end", {31'b0, testBusy}, 0);
    chk("R11 no restart, low arrays", wrCnt[0], 5 * D);
    chk("R11 no restart, high arrays", wrCnt[5], 5 * D);
    shiftOut(v, extra);
    chk("R11 vector intact", {23'b0, v}, 32'h004);
  endtask

  task automatic testFloat();
    clearFaults();
    applyReset(1, 1);
    repeat (2) @(negedge clk);
    chk("R3 padOe low", {31'b0, padOe}, 0);
    chk("R3 no start-up", {31'b0, startupGo}, 0);
    runSelfTest = 1; @(negedge clk); runSelfTest = 0;
    repeat (50) @(negedge clk);
    chk("R3 command ignored", {31'b0, testBusy}, 0);
    chk("R3 no writes", wrCnt[0] + wrCnt[4], 0);
    chk("R3 outputs held", {resultWord[30:0], tdo}, 0);
    chk("R3 still floating", {31'b0, padOe}, 0);
    applyReset(0, 0);
    @(negedge clk);
    chk("R3 reset leaves float", {30'b0, padOe, startupGo}, 32'd3);
  endtask

  initial begin
    testResetState();
    testNoInit();
    testPassRun();
    testArrayFaults();
    testSigFaults();
    testAllFaults();
    testRunBist();
    testTapClear();
    testBusyIgnore();
    testFloat();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule